// File: doc/BRIEF.md
# Receive FIFO Watermark Bus Arbiter

This block decides when the receive DMA engine should ask for the system bus, whether that request is urgent, and how many words the next burst may carry. It compares the receive FIFO fill level with two programmable watermarks. Each watermark is a 3-bit field `m` that stands for `m * DEPTH / 8` words. The urgent flag turns on at the upper watermark and stays on until the FIFO drains to the lower watermark, so the flag does not chatter while the level sits between the two marks.

The burst size is the largest length that meets three limits at once. Its capability bit must be set, the FIFO must already hold that many words, and the length must not exceed the maximum-burst cap. The block reads a single grant input. While the grant is high, the burst length is frozen and the request is withdrawn. The bus handshake itself happens outside this block. All three outputs are registered and reflect the inputs sampled at the previous clock edge.

Top module: `rx_wm_arb`

## Requirements
- R1: While `rst_n` is low, `req` and `hi_prio` are 0 and `burst_len` is 1.
- R2: With `arb_en`=1, `hi_prio` is 1 one cycle after `fill >= hi_mark*DEPTH/8`. When both marks are met in the same cycle, setting wins.
- R3: With `arb_en`=1 and `fill` below the upper mark, `hi_prio` clears one cycle after `fill <= lo_mark*DEPTH/8`. Strictly between the two marks, `hi_prio` holds its value.
- R4: With `arb_en`=0, `hi_prio` is 0 one cycle later. In that mode `req` is 1 whenever `fill` is non-zero and `bus_gnt` is 0.
- R5: `burst_len` is the largest capability whose bit is set that fits both `fill` and the cap. The capabilities are `cap_en[0]` for 4 words, `cap_en[1]` for 8 and `cap_en[2]` for 16. When no capability qualifies, `burst_len` is 1.
- R6: `max_burst` sets the cap. Values 0 and 1 mean unlimited, 2 means 32 words and 3 means 64 words, so the cap never cuts below 16.
- R7: With `arb_en`=1, `req` is 1 one cycle after a cycle in which all of the following hold: `fill` is non-zero, `bus_gnt` is 0, and at least one of these is true: `cap_en`=0, an enabled burst fits, or the next `hi_prio` is 1.
- R8: A cycle with `bus_gnt`=1 gives `req`=0 and an unchanged `burst_len` in the next cycle.
- R9: An empty FIFO (`fill`=0) gives `req`=0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill | input | LVL_W | Receive FIFO fill level in words |
| arb_en | input | 1 | Watermark arbitration enable |
| hi_mark | input | 3 | Upper watermark in eighths of the depth |
| lo_mark | input | 3 | Lower watermark in eighths of the depth |
| cap_en | input | 3 | Burst capability bits (4, 8, 16 words) |
| max_burst | input | 2 | Maximum-burst cap code |
| bus_gnt | input | 1 | Bus grant |
| req | output | 1 | Bus request |
| hi_prio | output | 1 | Urgent-request flag |
| burst_len | output | LEN_W | Burst length in words |

## Verification
Two events can fall in the same cycle: a watermark crossing that changes `hi_prio`, and a grant that freezes `burst_len` and withdraws `req`. The bench provokes this directly by raising `fill` past the upper mark in the same cycle that `bus_gnt` is high. It then checks three things: the flag sets, the request stays low, and the length keeps the value it had before the grant. Random cycles mix grants with fill swings across both marks. Every output is compared against a bench model of the hysteresis and burst selection.

// File: rtl/rx_wm_arb.sv
module rx_wm_arb #(
  parameter int DEPTH = 64,
  parameter int LVL_W = $clog2(DEPTH + 1),
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fill,
  input  logic             arb_en,
  input  logic [2:0]       hi_mark,
  input  logic [2:0]       lo_mark,
  input  logic [2:0]       cap_en,
  input  logic [1:0]       max_burst,
  input  logic             bus_gnt,
  output logic             req,
  output logic             hi_prio,
  output logic [LEN_W-1:0] burst_len
);
  localparam int CAPS = 3;
  localparam logic [LVL_W-1:0] EIGHTH = LVL_W'(DEPTH / 8);

  logic [LVL_W-1:0] hi_thr, lo_thr;
  logic [CAPS-1:0]  fit;
  logic [LEN_W-1:0] cand;
  logic             hi_nx, req_nx;

  assign hi_thr = LVL_W'(hi_mark) * EIGHTH;
  assign lo_thr = LVL_W'(lo_mark) * EIGHTH;

  for (genvar c = 0; c < CAPS; c++) begin : g_cap
    localparam logic [LVL_W-1:0] WORDS = LVL_W'(4 << c);
    localparam logic [7:0] WORDS8 = 8'(4 << c);
    logic under_cap;
    assign under_cap = (max_burst < 2'd2) ||
                       (WORDS8 <= ((max_burst == 2'd2) ? 8'd32 : 8'd64));
    assign fit[c] = cap_en[c] && (fill >= WORDS) && under_cap;
  end

  always_comb begin
    cand = LEN_W'(1);
    for (int c = 0; c < CAPS; c++)
      if (fit[c]) cand = LEN_W'(4 << c);
  end

  always_comb begin
    if (!arb_en)               hi_nx = 1'b0;
    else if (fill >= hi_thr)   hi_nx = 1'b1;
    else if (fill <= lo_thr)   hi_nx = 1'b0;
    else                       hi_nx = hi_prio;
  end

  assign req_nx = !bus_gnt && (fill != '0) &&
                  (!arb_en || (cap_en == '0) || (|fit) || hi_nx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_prio   <= 1'b0;
      req       <= 1'b0;
      burst_len <= LEN_W'(1);
    end else begin
      hi_prio <= hi_nx;
      req     <= req_nx;
      if (!bus_gnt) burst_len <= cand;
    end
  end
endmodule

// File: rtl/rx_wm_arb_chk.sv
module rx_wm_arb_chk #(
  parameter int DEPTH = 64,
  parameter int LVL_W = $clog2(DEPTH + 1),
  parameter int LEN_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] fill,
  input logic             arb_en,
  input logic [2:0]       hi_mark,
  input logic [2:0]       lo_mark,
  input logic             bus_gnt,
  input logic             req,
  input logic             hi_prio,
  input logic [LEN_W-1:0] burst_len
);
  logic [LVL_W-1:0] th_hi, th_lo;
  assign th_hi = LVL_W'(hi_mark) * LVL_W'(DEPTH / 8);
  assign th_lo = LVL_W'(lo_mark) * LVL_W'(DEPTH / 8);

  p_prio_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arb_en && fill >= th_hi |=> hi_prio);
  p_prio_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arb_en && fill < th_hi && fill <= th_lo |=> !hi_prio);
  p_prio_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arb_en && fill < th_hi && fill > th_lo |=> $stable(hi_prio));
  p_prio_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_en |=> !hi_prio);
  p_open_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_en && !bus_gnt && fill != '0 |=> req);
  p_len_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(burst_len) == 1 && burst_len != LEN_W'(2));
  p_gnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_gnt |=> !req && $stable(burst_len));
  p_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill == '0 |=> !req);
endmodule

bind rx_wm_arb rx_wm_arb_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fill(fill), .arb_en(arb_en), .hi_mark(hi_mark),
  .lo_mark(lo_mark), .bus_gnt(bus_gnt), .req(req), .hi_prio(hi_prio),
  .burst_len(burst_len)
);

// File: tb/sim_rx_wm_arb.sv
module sim_rx_wm_arb;
  localparam int PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int LEN_W = 5;

  logic clk = 0, rst_n = 0;
  logic [LVL_W-1:0] fill = '0;
  logic arb_en = 0, bus_gnt = 0;
  logic [2:0] hi_mark = 0, lo_mark = 0, cap_en = 0;
  logic [1:0] max_burst = 0;
  logic req, hi_prio;
  logic [LEN_W-1:0] burst_len;

  int total = 0, bad = 0;
  bit m_hi = 0;
  int m_len = 1;

  always #(PERIOD/2) clk = ~clk;

  rx_wm_arb #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .fill(fill), .arb_en(arb_en), .hi_mark(hi_mark),
    .lo_mark(lo_mark), .cap_en(cap_en), .max_burst(max_burst), .bus_gnt(bus_gnt),
    .req(req), .hi_prio(hi_prio), .burst_len(burst_len)
  );

  function automatic bit f_hi(int f, bit en, int hm, int lm, bit cur);
    if (!en) return 0;
    if (f >= hm * DEPTH / 8) return 1;
    if (f <= lm * DEPTH / 8) return 0;
    return cur;
  endfunction

  function automatic int f_len(int f, int cap, int mb);
    int lim = (mb == 2) ? 32 : (mb == 3) ? 64 : 1 << 20;
    int best = 1;
    for (int c = 0; c < 3; c++) begin
      int w = 4 << c;
      if (cap[c] && f >= w && w <= lim) best = w;
    end
    return best;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(int f, bit en, int hm, int lm, int cap, int mb, bit g, string tag);
    bit e_hi, e_req;
    int e_len, cl;
    fill = LVL_W'(f); arb_en = en; hi_mark = 3'(hm); lo_mark = 3'(lm);
    cap_en = 3'(cap); max_burst = 2'(mb); bus_gnt = g;
    e_hi = f_hi(f, en, hm, lm, m_hi);
    cl = f_len(f, cap, mb);
    e_len = g ? m_len : cl;
    e_req = !g && f != 0 && (!en || cap == 0 || cl > 1 || e_hi);
    @(posedge clk); @(negedge clk);
    check(tag, "hi_prio", hi_prio, e_hi);
    check(tag, "req", req, e_req);
    check(tag, "burst_len", burst_len, e_len);
    m_hi = e_hi; m_len = e_len;
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    fill = 7'd40; arb_en = 1; cap_en = 3'b111;
    repeat (3) @(negedge clk);
    check("R1", "req", req, 0);
    check("R1", "hi_prio", hi_prio, 0);
    check("R1", "burst_len", burst_len, 1);
    rst_n = 1;

    step(0,  1, 6, 2, 3'b111, 0, 0, "R9");
    step(50, 1, 6, 2, 3'b000, 0, 0, "R2");
    step(40, 1, 6, 2, 3'b000, 0, 0, "R3");
    step(17, 1, 6, 2, 3'b000, 0, 0, "R3");
    step(16, 1, 6, 2, 3'b000, 0, 0, "R3");
    step(30, 1, 6, 2, 3'b000, 0, 0, "R3");
    step(10, 1, 6, 2, 3'b011, 0, 0, "R5");
    step(20, 1, 6, 2, 3'b111, 2, 0, "R6");
    step(20, 1, 6, 2, 3'b111, 3, 0, "R6");
    step(15, 1, 6, 2, 3'b111, 1, 0, "R5");
    step(5,  1, 6, 2, 3'b010, 0, 0, "R7");
    step(3,  1, 6, 2, 3'b001, 0, 0, "R7");
    step(2,  1, 6, 2, 3'b000, 0, 0, "R7");
    step(3,  0, 6, 2, 3'b100, 0, 0, "R4");
    step(60, 0, 6, 2, 3'b100, 0, 0, "R4");
    step(8,  1, 6, 2, 3'b111, 0, 0, "R5");
    step(55, 1, 6, 2, 3'b111, 0, 1, "R8");
    step(55, 1, 6, 2, 3'b111, 0, 0, "R8");
    step(20, 1, 2, 4, 3'b000, 0, 0, "R2");

    for (int i = 0; i < 400; i++) begin
      int f = (i % 7 == 0) ? 0 : $urandom_range(0, DEPTH);
      step(f, ($urandom_range(0, 7) != 0), $urandom_range(0, 7), $urandom_range(0, 7),
           $urandom_range(0, 7), $urandom_range(0, 3), ($urandom_range(0, 3) == 0), "R7");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule